// File: doc/BRIEF.md
# Counter Block Incrementer with Selectable Field Width

This block holds the 128-bit counter block used by counter-based cipher modes and advances it by one on request. A load captures an initial block from the IV input. Each accepted step then adds one to a low-order counter field of the held block. The bits above that field are passed through unchanged, so when the field wraps around, no carry reaches them. The cipher core and the XOR with payload data sit outside this block. They consume `ctr_o` whenever `valid_o` is high.

The field width is fixed at load time. It comes from a mode code and, for the plain counter mode, a width code. Integer counter mode uses a 16-bit field. GCM uses a 32-bit field and also counts the blocks issued since the load. Once that count reaches the programmed limit, any further step request is refused and a sticky error flag is raised.

Top module: `ctr_blk_inc`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first load, `ctr_o` is 0, `valid_o` is 0 and `ovf_o` is 0.
- R2: A clock edge with `load_i` high sets the following values, visible in the next cycle:
  - `ctr_o` takes the value of `iv_i`. IV word k (k=0..3) sits at `iv_i[32k+31:32k]`, with word 0 least significant.
  - `valid_o` becomes 1.
  - `ovf_o` becomes 0.
  - The GCM block count is cleared.
- R3: In mode code 0 or 3 (plain counter), a step adds one modulo 2^W to `ctr_o[W-1:0]` and leaves the bits above W unchanged. W is chosen by width code 0 = 32, 1 = 64, 2 = 128.
- R4: Width code 3 in plain counter mode asks for 192 bits. Because the block is only 128 bits wide, it behaves exactly like width code 2: the whole block increments and wraps to zero.
- R5: In mode code 1 (integer counter), a step increments only `ctr_o[15:0]` modulo 2^16, whatever the width code.
- R6: In mode code 2 (GCM), a step increments only `ctr_o[31:0]` modulo 2^32, whatever the width code.
- R7: GCM block limit:
  - In GCM, at most `GCM_MAX_BLOCKS` steps are accepted after a load (default 2^32-2).
  - A step requested after that leaves `ctr_o` unchanged and sets `ovf_o` in the next cycle.
  - `ovf_o` then stays 1 until the next load.
  - Other modes never set `ovf_o`.
- R8: A step requested while `valid_o` is 0 has no effect on `ctr_o` or `valid_o`.
- R9: When `load_i` and `step_i` are high on the same edge, the load wins and the step is dropped.
- R10: With `load_i` and `step_i` both low, `ctr_o`, `valid_o` and `ovf_o` hold their values.
- R11: `mode_i` and `width_i` are sampled only on a load. Changing them between loads does not change the field width or the limit checking of later steps.
- R12: Each accepted step updates `ctr_o` in the cycle right after the edge that sampled `step_i`. `valid_o` stays high from the first load onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture `iv_i`, latch mode and width, clear error and count |
| step_i | input | 1 | Request one counter increment |
| mode_i | input | 2 | 0 plain counter, 1 integer counter, 2 GCM, 3 plain counter |
| width_i | input | 2 | Plain counter field width: 0=32, 1=64, 2=128, 3=192 (acts as 128) |
| iv_i | input | 128 | Initial counter block, word 0 in bits [31:0] |
| ctr_o | output | 128 | Current counter block |
| valid_o | output | 1 | Counter block holds loaded data |
| ovf_o | output | 1 | Sticky GCM block-limit error |

## Verification
Every result of this block is registered once. A load, an accepted step, a refused GCM step and the rise of `ovf_o` all appear in the cycle after the rising edge that sampled the request. The bench changes inputs on the falling edge and lets one rising edge pass. It advances its reference model for that same edge and compares all outputs at the next falling edge, half a cycle before the following rising edge. The bench builds its model on a masked add of one, not on lane carries. It lowers the GCM limit to a handful of blocks so that the refusal and the sticky flag are reached within a short run.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;

  typedef enum logic [1:0] {
    MODE_CTR  = 2'd0,
    MODE_ICM  = 2'd1,
    MODE_GCM  = 2'd2,
    MODE_CTR3 = 2'd3
  } ctr_mode_e;

  localparam int unsigned ICM_FIELD_W = 16;
  localparam int unsigned GCM_FIELD_W = 32;

  // field width in bits requested by a mode / width code pair
  function automatic int unsigned field_bits(input ctr_mode_e mode, input logic [1:0] wcode);
    int unsigned b;
    case (mode)
      MODE_ICM: b = ICM_FIELD_W;
      MODE_GCM: b = GCM_FIELD_W;
      default: begin
        case (wcode)
          2'd0:    b = 32;
          2'd1:    b = 64;
          2'd2:    b = 128;
          default: b = 192;
        endcase
      end
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ctr_lane_sel.sv
module ctr_lane_sel #(
  parameter int unsigned BLK_W   = 128,
  parameter int unsigned LANE_W  = 16,
  localparam int unsigned N_LANES = BLK_W / LANE_W
) (
  input  logic [1:0]         mode_i,
  input  logic [1:0]         width_i,
  output logic [N_LANES-1:0] lane_en_o
);
  import ctr_inc_pkg::*;

  int unsigned n_lanes;

  always_comb begin
    n_lanes = field_bits(ctr_mode_e'(mode_i), width_i) / LANE_W;
    if (n_lanes > N_LANES) n_lanes = N_LANES;
    for (int unsigned k = 0; k < N_LANES; k++) begin
      lane_en_o[k] = (k < n_lanes);
    end
  end

endmodule

// File: rtl/ctr_lane_inc.sv
module ctr_lane_inc #(
  parameter int unsigned BLK_W   = 128,
  parameter int unsigned LANE_W  = 16,
  localparam int unsigned N_LANES = BLK_W / LANE_W
) (
  input  logic [BLK_W-1:0]   ctr_i,
  input  logic [N_LANES-1:0] lane_en_i,
  output logic [BLK_W-1:0]   ctr_o
);

  logic [N_LANES-1:0] cy;
  assign cy[0] = 1'b1;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] sum;
    assign lane = ctr_i[k*LANE_W +: LANE_W];
    assign sum  = lane + LANE_W'(cy[k]);
    assign ctr_o[k*LANE_W +: LANE_W] = lane_en_i[k] ? sum : lane;
    // carry stops at the first lane outside the field
    if (k < N_LANES - 1) begin : g_cy
      assign cy[k+1] = lane_en_i[k] & cy[k] & (&lane);
    end
  end

endmodule

// File: rtl/ctr_gcm_limit.sv
module ctr_gcm_limit #(
  parameter longint unsigned MAX_BLOCKS = 64'd4294967294,
  localparam int unsigned    CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic at_limit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q >= CNT_W'(MAX_BLOCKS));

endmodule

// File: rtl/ctr_blk_inc.sv
module ctr_blk_inc #(
  parameter int unsigned     BLK_W          = 128,
  parameter int unsigned     LANE_W         = 16,
  parameter longint unsigned GCM_MAX_BLOCKS = 64'd4294967294,
  localparam int unsigned    N_LANES        = BLK_W / LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       width_i,
  input  logic [BLK_W-1:0] iv_i,
  output logic [BLK_W-1:0] ctr_o,
  output logic             valid_o,
  output logic             ovf_o
);
  import ctr_inc_pkg::*;

  logic [BLK_W-1:0]   ctr_q, ctr_nxt;
  logic [N_LANES-1:0] lane_en_d, lane_en_q;
  logic               valid_q, ovf_q, gcm_q;
  logic               step_req, step_ok, at_limit;

  ctr_lane_sel #(.BLK_W(BLK_W), .LANE_W(LANE_W)) u_sel (
    .mode_i    (mode_i),
    .width_i   (width_i),
    .lane_en_o (lane_en_d)
  );

  ctr_lane_inc #(.BLK_W(BLK_W), .LANE_W(LANE_W)) u_inc (
    .ctr_i     (ctr_q),
    .lane_en_i (lane_en_q),
    .ctr_o     (ctr_nxt)
  );

  ctr_gcm_limit #(.MAX_BLOCKS(GCM_MAX_BLOCKS)) u_lim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load_i),
    .adv_i      (step_ok & gcm_q),
    .at_limit_o (at_limit)
  );

  assign step_req = step_i & valid_q & ~load_i;
  assign step_ok  = step_req & ~(gcm_q & at_limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q     <= '0;
      valid_q   <= 1'b0;
      ovf_q     <= 1'b0;
      gcm_q     <= 1'b0;
      lane_en_q <= '0;
    end else if (load_i) begin
      ctr_q     <= iv_i;
      valid_q   <= 1'b1;
      ovf_q     <= 1'b0;
      gcm_q     <= (ctr_mode_e'(mode_i) == MODE_GCM);
      lane_en_q <= lane_en_d;
    end else if (step_ok) begin
      ctr_q <= ctr_nxt;
    end else if (step_req) begin
      ovf_q <= 1'b1;
    end
  end

  assign ctr_o   = ctr_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/ctr_blk_inc_chk.sv
module ctr_blk_inc_chk #(
  parameter int unsigned BLK_W   = 128,
  parameter int unsigned LANE_W  = 16,
  localparam int unsigned N_LANES = BLK_W / LANE_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               step_i,
  input logic [BLK_W-1:0]   iv_i,
  input logic [BLK_W-1:0]   ctr_o,
  input logic               valid_o,
  input logic               ovf_o,
  input logic [N_LANES-1:0] lane_en_q,
  input logic               gcm_q
);

  logic [BLK_W-1:0] fmask;
  logic             try_step;

  always_comb begin
    for (int unsigned k = 0; k < N_LANES; k++) begin
      fmask[k*LANE_W +: LANE_W] = {LANE_W{lane_en_q[k]}};
    end
  end

  assign try_step = valid_o & step_i & ~load_i & ~ovf_o;

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ctr_o == $past(iv_i)) && valid_o && !ovf_o); // R2

  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_step |=> ovf_o || ((ctr_o & ~fmask) == ($past(ctr_o) & ~fmask))); // R3

  AST_LOW_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_step |=> ovf_o || (ctr_o[LANE_W-1:0] == $past(ctr_o[LANE_W-1:0]) + 1'b1)); // R12

  AST_OVF_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ctr_o == $past(ctr_o)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !load_i) |=> ovf_o); // R7

  AST_OVF_GCM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> gcm_q); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(ctr_o) && $stable(ovf_o)); // R10

  AST_NOT_VALID_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> !valid_o && $stable(ctr_o)); // R8

  AST_VALID_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R12

endmodule

bind ctr_blk_inc ctr_blk_inc_chk #(.BLK_W(BLK_W), .LANE_W(LANE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .step_i    (step_i),
  .iv_i      (iv_i),
  .ctr_o     (ctr_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o),
  .lane_en_q (lane_en_q),
  .gcm_q     (gcm_q)
);

// File: tb/ctr_blk_inc_bench.sv
`timescale 1ns/1ps
module ctr_blk_inc_bench;

  localparam int unsigned LIM = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [1:0]   width_i = 2'd0;
  logic [127:0] iv_i = '0;
  logic [127:0] ctr_o;
  logic         valid_o, ovf_o;

  int checks = 0;
  int fails  = 0;

  logic [127:0] m_ctr = '0;
  logic         m_valid = 1'b0, m_ovf = 1'b0;
  logic [1:0]   m_mode = 2'd0, m_width = 2'd0;
  int unsigned  m_cnt = 0;

  always #10 clk_i = ~clk_i;

  ctr_blk_inc #(.GCM_MAX_BLOCKS(64'(LIM))) u_ctr_blk_inc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
    .mode_i(mode_i), .width_i(width_i), .iv_i(iv_i),
    .ctr_o(ctr_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  function automatic int unsigned ref_bits(input logic [1:0] md, input logic [1:0] wd);
    if (md == 2'd1) return 16;
    if (md == 2'd2) return 32;
    if (wd == 2'd0) return 32;
    if (wd == 2'd1) return 64;
    return 128;
  endfunction

  function automatic logic [127:0] ref_next(input logic [127:0] c, input int unsigned b);
    logic [127:0] m;
    m = (b >= 128) ? {128{1'b1}} : ((128'd1 << b) - 128'd1);
    return (c & ~m) | ((c + 128'd1) & m);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (ctr_o !== m_ctr || valid_o !== m_valid || ovf_o !== m_ovf) begin
      fails++;
      $display("FAIL %s: ctr=%h valid=%b ovf=%b expected ctr=%h valid=%b ovf=%b",
               tag, ctr_o, valid_o, ovf_o, m_ctr, m_valid, m_ovf);
    end
  endtask

  // drive at falling edge, model the next rising edge, compare at following falling edge
  task automatic cyc(input logic ld, input logic st, input logic [1:0] md,
                     input logic [1:0] wd, input logic [127:0] iv, input string tag);
    load_i = ld; step_i = st; mode_i = md; width_i = wd; iv_i = iv;
    @(posedge clk_i);
    if (ld) begin
      m_ctr = iv; m_valid = 1'b1; m_ovf = 1'b0; m_mode = md; m_width = wd; m_cnt = 0;
    end else if (st && m_valid) begin
      if (m_mode == 2'd2 && m_cnt >= LIM) m_ovf = 1'b1;
      else begin
        m_ctr = ref_next(m_ctr, ref_bits(m_mode, m_width));
        if (m_mode == 2'd2) m_cnt++;
      end
    end
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not complete, expected end within limit");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    void'($urandom(32'd20240611));
    pat = 128'hA5A5_1234_5A5A_9876_0F0F_F0F0_CAFE_BEEF;
    repeat (2) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, '0, "R1 after release");
    cyc(0, 1, 0, 0, pat, "R8 step before load");
    cyc(1, 1, 0, 0, pat, "R9 load beats step");
    cyc(0, 0, 0, 0, '0, "R10 hold");
    cyc(0, 1, 0, 0, '0, "R3 step w32");
    // wrap cases per width
    cyc(1, 0, 0, 0, {pat[127:32], 32'hFFFF_FFFF}, "R2 load");
    cyc(0, 1, 0, 0, '0, "R3 wrap w32");
    cyc(1, 0, 0, 1, {pat[127:64], 64'hFFFF_FFFF_FFFF_FFFF}, "R2 load");
    cyc(0, 1, 0, 0, '0, "R3 wrap w64");
    cyc(0, 1, 1, 3, '0, "R11 width change ignored");
    cyc(1, 0, 0, 2, {128{1'b1}}, "R2 load");
    cyc(0, 1, 0, 0, '0, "R3 wrap w128");
    cyc(1, 0, 0, 3, {128{1'b1}}, "R2 load");
    cyc(0, 1, 0, 0, '0, "R4 wrap code3");
    cyc(1, 0, 3, 0, {pat[127:32], 32'hFFFF_FFFF}, "R2 load");
    cyc(0, 1, 0, 0, '0, "R3 mode3 wrap");
    cyc(1, 0, 1, 2, {pat[127:16], 16'hFFFF}, "R2 load");
    cyc(0, 1, 0, 2, '0, "R5 icm wrap");
    cyc(0, 1, 0, 2, '0, "R5 icm step");
    cyc(1, 0, 2, 2, {pat[127:32], 32'hFFFF_FFFE}, "R2 load");
    for (int i = 0; i < LIM; i++) cyc(0, 1, 0, 0, '0, "R6 gcm step");
    cyc(0, 1, 0, 0, '0, "R7 gcm limit refused");
    cyc(0, 0, 0, 0, '0, "R7 ovf sticky");
    cyc(0, 1, 0, 0, '0, "R7 still refused");
    cyc(1, 0, 0, 0, pat, "R7 load clears ovf");
    for (int i = 0; i < 3 * LIM; i++) cyc(0, 1, 2, 0, '0, "R11 no gcm limit after mode change");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [127:0] iv;
      iv = rnd128();
      if ($urandom % 3 == 0) iv[63:0] = {64{1'b1}} - 64'($urandom % 3);
      cyc(($urandom % 8) == 0, ($urandom % 4) != 0, 2'($urandom), 2'($urandom), iv,
          "R12 random mix");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule